// File: doc/BRIEF.md
# Flash Program/Erase Status Byte Generator

This block forms the byte that a parallel flash device returns on its data pins while an embedded program or erase is running, while an erase is suspended, or just after such an operation has failed. Software polls this byte to learn whether the operation is still in progress, which block is being erased, whether the erase window is still open, and whether the operation failed. When no operation is active and no fault is latched, the array data passes straight through.

The device controller supplies the current operating mode, a mask of the blocks selected for erase (or held in suspend), the block being read, the array data at the read address and the data byte being programmed. It also supplies single-cycle event pulses for a fault, a 0-to-1 overwrite attempt, a successful completion, a Read/Reset command, acceptance of the last block-erase command, and an erase that found every selected block protected. The raw output-enable and chip-enable pins (both active low) feed a read-strobe detector that drives the toggle bits. The erase-timer window and the protected-abort window are counted in clock cycles set by parameters.

Top module: `fsb_status_gen`

## Requirements
- R1: With the mode idle (code 0), no fault latched and no protected-abort window open, `status_o` equals `array_q`. Mode codes 5 to 7 also pass `array_q` through.
- R2: In program mode (code 1) and suspend-program mode (code 4), bit 7 is the inverse of `wr_data[7]`, bit 2 is 1, bits 3, 4, 1 and 0 are 0, and bit 5 is the fault flag.
- R3: In erase mode (code 2), bit 7 is 0, bits 4, 1 and 0 are 0 and bit 5 is the fault flag.
- R4: In suspend-read mode (code 3), a read of a block whose `erase_mask` bit is set returns 1 on bits 7 and 6, the secondary toggle on bit 2, the fault flag on bit 5 and 0 elsewhere; a read of any other block returns `array_q` unchanged.
- R5: A read strobe is a rising edge of `oe_n`, or a rising edge of `ce_n` while `oe_n` is low; a rising `ce_n` with `oe_n` high is not a strobe. In program, erase and suspend-program modes bit 6 inverts on the clock edge that samples each strobe and holds otherwise.
- R6: In erase mode, bit 2 inverts with each strobe made while the read block is in `erase_mask` and reads 1 for other blocks; in suspend-read mode it inverts with each strobe on a masked block.
- R7: A `fault_pulse` or `overwrite_pulse` sets the fault flag and latches `fault_blk`; `cmd_reset` or `done_ok` clears it; a set in the same cycle as a clear wins.
- R8: In idle mode with the fault flag set (and no protected window), `status_o` has bit 5 set and every other bit 0 except bit 2, which toggles per strobe when `rd_blk` equals the latched failing block and is 1 otherwise.
- R9: After `erase_armed` is sampled, bit 3 reads 0 in erase mode for `TMO_CYCLES` clock cycles and then returns to 1.
- R10: After `prot_abort` is sampled, idle mode shows bit 6 as a toggle advancing with each strobe, bit 2 as 1 and bit 5 as the fault flag for `PROT_CYCLES` cycles, then returns to R1 or R8 behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 3 | Controller mode: 0 idle, 1 program, 2 erase, 3 suspend-read, 4 suspend-program |
| erase_mask | input | NUM_BLOCKS | One bit per block selected for (or suspended in) erase |
| rd_blk | input | BLK_W | Block index of the current read address |
| array_q | input | 8 | Stored array data at the read address |
| wr_data | input | 8 | Byte being programmed |
| fault_pulse | input | 1 | Program or erase failure |
| overwrite_pulse | input | 1 | Attempt to program a 1 over a 0 |
| fault_blk | input | BLK_W | Block associated with a fault or overwrite |
| done_ok | input | 1 | Successful completion, clears fault flag |
| cmd_reset | input | 1 | Read/Reset command, clears fault flag |
| erase_armed | input | 1 | Last block-erase command accepted, opens timer window |
| prot_abort | input | 1 | Erase found all selected blocks protected |
| oe_n | input | 1 | Output enable pin, active low |
| ce_n | input | 1 | Chip enable pin, active low |
| status_o | output | 8 | Status byte or pass-through array data |

## Verification
The bench drives chip-enable edges while output-enable is high, which a detector that ignored the output-enable qualifier would count as reads and so flip bit 6 when it must hold. It alternates reads between masked and unmasked blocks in erase and suspend, where a design that toggled the secondary bit per strobe regardless of address would drift out of phase with the masked block. It raises a fault and a clear in the same cycle, where a wrong priority would drop the fault flag, and it watches the timer and protected windows at their exact final cycle, where an off-by-one counter would release bit 3 or bit 6 a cycle early or late.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE    = 3'd0,
        MODE_PROG    = 3'd1,
        MODE_ERASE   = 3'd2,
        MODE_SUSP_RD = 3'd3,
        MODE_SUSP_PG = 3'd4
    } fsb_mode_e;

    typedef struct packed {
        logic poll;
        logic tgl_a;
        logic fault;
        logic tmr;
        logic tgl_b;
    } fsb_flags_t;

    localparam int POS_POLL  = 7;
    localparam int POS_TGL_A = 6;
    localparam int POS_FAULT = 5;
    localparam int POS_TMR   = 3;
    localparam int POS_TGL_B = 2;

    function automatic logic [7:0] fsb_pack(input fsb_flags_t f);
        logic [7:0] b;
        b            = 8'h00;
        b[POS_POLL]  = f.poll;
        b[POS_TGL_A] = f.tgl_a;
        b[POS_FAULT] = f.fault;
        b[POS_TMR]   = f.tmr;
        b[POS_TGL_B] = f.tgl_b;
        return b;
    endfunction

    function automatic logic mode_runs_op(input fsb_mode_e m);
        return (m == MODE_PROG) || (m == MODE_ERASE) || (m == MODE_SUSP_PG);
    endfunction

endpackage

// File: rtl/fsb_read_strobe.sv
module fsb_read_strobe (
    input  logic clk,
    input  logic rst,
    input  logic oe_n,
    input  logic ce_n,
    output logic strobe
);
    logic oe_prev;
    logic ce_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_prev <= 1'b1;
            ce_prev <= 1'b1;
        end else begin
            oe_prev <= oe_n;
            ce_prev <= ce_n;
        end
    end

    logic oe_rise;
    logic ce_rise_gated;
    assign oe_rise       = oe_n & ~oe_prev;
    assign ce_rise_gated = ce_n & ~ce_prev & ~oe_n;
    assign strobe        = oe_rise | ce_rise_gated;
endmodule

// File: rtl/fsb_countdown.sv
module fsb_countdown #(
    parameter int LEN = 16,
    localparam int CW = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam logic [CW-1:0] LOAD_VAL = CW'(LEN);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD_VAL;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/fsb_toggle_bit.sv
module fsb_toggle_bit (
    input  logic clk,
    input  logic rst,
    input  logic flip,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (flip) begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/fsb_fault_track.sv
module fsb_fault_track #(
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_a,
    input  logic          set_b,
    input  logic [BW-1:0] set_blk,
    input  logic          clr_a,
    input  logic          clr_b,
    output logic          flag,
    output logic [BW-1:0] blk
);
    logic any_set;
    logic any_clr;
    assign any_set = set_a | set_b;
    assign any_clr = clr_a | clr_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            blk  <= '0;
        end else if (any_set) begin
            flag <= 1'b1;
            blk  <= set_blk;
        end else if (any_clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/fsb_status_gen.sv
module fsb_status_gen
    import fsb_pkg::*;
#(
    parameter int NUM_BLOCKS  = 8,
    parameter int TMO_CYCLES  = 400,
    parameter int PROT_CYCLES = 800,
    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            op_mode,
    input  logic [NUM_BLOCKS-1:0] erase_mask,
    input  logic [BLK_W-1:0]      rd_blk,
    input  logic [7:0]            array_q,
    input  logic [7:0]            wr_data,
    input  logic                  fault_pulse,
    input  logic                  overwrite_pulse,
    input  logic [BLK_W-1:0]      fault_blk,
    input  logic                  done_ok,
    input  logic                  cmd_reset,
    input  logic                  erase_armed,
    input  logic                  prot_abort,
    input  logic                  oe_n,
    input  logic                  ce_n,
    output logic [7:0]            status_o
);
    fsb_mode_e mode;
    assign mode = fsb_mode_e'(op_mode);

    logic rd_strobe;
    fsb_read_strobe u_strobe (
        .clk(clk), .rst(rst), .oe_n(oe_n), .ce_n(ce_n), .strobe(rd_strobe)
    );

    logic             err_q;
    logic [BLK_W-1:0] err_blk;
    fsb_fault_track #(.BW(BLK_W)) u_fault (
        .clk(clk), .rst(rst),
        .set_a(fault_pulse), .set_b(overwrite_pulse), .set_blk(fault_blk),
        .clr_a(cmd_reset), .clr_b(done_ok),
        .flag(err_q), .blk(err_blk)
    );

    // window timers: index 0 = erase timer, index 1 = protected abort
    localparam int NWIN = 2;
    logic [NWIN-1:0] win_start;
    logic [NWIN-1:0] win_busy;
    assign win_start = {prot_abort, erase_armed};

    genvar gw;
    generate
        for (gw = 0; gw < NWIN; gw++) begin : g_win
            localparam int WLEN = (gw == 0) ? TMO_CYCLES : PROT_CYCLES;
            fsb_countdown #(.LEN(WLEN)) u_cd (
                .clk(clk), .rst(rst), .start(win_start[gw]), .busy(win_busy[gw])
            );
        end
    endgenerate

    logic tmr_pending;
    logic prot_busy;
    assign tmr_pending = win_busy[0];
    assign prot_busy   = win_busy[1];

    logic blk_in_mask;
    logic fault_hit;
    assign blk_in_mask = erase_mask[rd_blk];
    assign fault_hit   = err_q && (rd_blk == err_blk);

    logic idle_prot;
    logic idle_fault;
    assign idle_prot  = (mode == MODE_IDLE) && prot_busy;
    assign idle_fault = (mode == MODE_IDLE) && !prot_busy && err_q;

    // toggle enables: index 0 = primary (bit 6), index 1 = secondary (bit 2)
    logic [1:0] tgl_flip;
    logic [1:0] tgl_q;
    assign tgl_flip[0] = rd_strobe && (mode_runs_op(mode) || idle_prot);
    assign tgl_flip[1] = rd_strobe &&
        ((((mode == MODE_ERASE) || (mode == MODE_SUSP_RD)) && blk_in_mask) ||
         (idle_fault && fault_hit));

    genvar gt;
    generate
        for (gt = 0; gt < 2; gt++) begin : g_tgl
            fsb_toggle_bit u_tb (
                .clk(clk), .rst(rst), .flip(tgl_flip[gt]), .q(tgl_q[gt])
            );
        end
    endgenerate

    fsb_flags_t fl;
    logic       pass_thru;

    always_comb begin
        fl        = '0;
        pass_thru = 1'b0;
        fl.fault  = err_q;
        unique case (mode)
            MODE_PROG, MODE_SUSP_PG: begin
                fl.poll  = ~wr_data[7];
                fl.tgl_a = tgl_q[0];
                fl.tgl_b = 1'b1;
            end
            MODE_ERASE: begin
                fl.poll  = 1'b0;
                fl.tgl_a = tgl_q[0];
                fl.tmr   = ~tmr_pending;
                fl.tgl_b = blk_in_mask ? tgl_q[1] : 1'b1;
            end
            MODE_SUSP_RD: begin
                if (blk_in_mask) begin
                    fl.poll  = 1'b1;
                    fl.tgl_a = 1'b1;
                    fl.tgl_b = tgl_q[1];
                end else begin
                    pass_thru = 1'b1;
                end
            end
            MODE_IDLE: begin
                if (prot_busy) begin
                    fl.tgl_a = tgl_q[0];
                    fl.tgl_b = 1'b1;
                end else if (err_q) begin
                    fl.tgl_b = fault_hit ? tgl_q[1] : 1'b1;
                end else begin
                    pass_thru = 1'b1;
                end
            end
            default: pass_thru = 1'b1;
        endcase
    end

    assign status_o = pass_thru ? array_q : fsb_pack(fl);

endmodule

// File: rtl/fsb_status_gen_chk.sv
module fsb_status_gen_chk #(
    parameter int NUM_BLOCKS = 8,
    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [2:0]            op_mode,
    input logic [NUM_BLOCKS-1:0] erase_mask,
    input logic [BLK_W-1:0]      rd_blk,
    input logic [7:0]            wr_data,
    input logic                  fault_pulse,
    input logic                  overwrite_pulse,
    input logic                  done_ok,
    input logic                  cmd_reset,
    input logic                  erase_armed,
    input logic [7:0]            status_o,
    input logic                  err_q,
    input logic                  rd_strobe
);
    p_prog_poll_r2: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 3'd1) |-> (status_o[7] != wr_data[7]));

    p_erase_poll_r3: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 3'd2) |-> !status_o[7]);

    p_susp_masked_r4: assert property (@(posedge clk) disable iff (rst)
        ((op_mode == 3'd3) && erase_mask[rd_blk]) |-> (status_o[7] && status_o[6]));

    p_tgl_flip_r5: assert property (@(posedge clk) disable iff (rst)
        ((op_mode == 3'd1) && rd_strobe) |=> ((op_mode != 3'd1) || (status_o[6] != $past(status_o[6]))));

    p_tgl_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ((op_mode == 3'd1) && !rd_strobe) |=> ((op_mode != 3'd1) || $stable(status_o[6])));

    p_fault_set_r7: assert property (@(posedge clk) disable iff (rst)
        (fault_pulse || overwrite_pulse) |=> err_q);

    p_fault_clr_r7: assert property (@(posedge clk) disable iff (rst)
        ((cmd_reset || done_ok) && !fault_pulse && !overwrite_pulse) |=> !err_q);

    p_timer_open_r9: assert property (@(posedge clk) disable iff (rst)
        erase_armed |=> ((op_mode != 3'd2) || !status_o[3]));
endmodule

bind fsb_status_gen fsb_status_gen_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk(clk), .rst(rst), .op_mode(op_mode), .erase_mask(erase_mask),
    .rd_blk(rd_blk), .wr_data(wr_data), .fault_pulse(fault_pulse),
    .overwrite_pulse(overwrite_pulse), .done_ok(done_ok), .cmd_reset(cmd_reset),
    .erase_armed(erase_armed), .status_o(status_o), .err_q(err_q),
    .rd_strobe(rd_strobe)
);

// File: tb/fsb_status_gen_tb_top.sv
module fsb_status_gen_tb_top;
    localparam int NB   = 8;
    localparam int BW   = 3;
    localparam int TMO  = 20;
    localparam int PROT = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    op_mode = 3'd0;
    logic [NB-1:0] erase_mask = '0;
    logic [BW-1:0] rd_blk = '0;
    logic [7:0]    array_q = 8'h00;
    logic [7:0]    wr_data = 8'h00;
    logic          fault_pulse = 0, overwrite_pulse = 0, done_ok = 0, cmd_reset = 0;
    logic [BW-1:0] fault_blk = '0;
    logic          erase_armed = 0, prot_abort = 0;
    logic          oe_n = 1'b1, ce_n = 1'b1;
    logic [7:0]    status_o;

    always #4 clk = ~clk;

    fsb_status_gen #(.NUM_BLOCKS(NB), .TMO_CYCLES(TMO), .PROT_CYCLES(PROT)) dut_i (
        .clk(clk), .rst(rst), .op_mode(op_mode), .erase_mask(erase_mask),
        .rd_blk(rd_blk), .array_q(array_q), .wr_data(wr_data),
        .fault_pulse(fault_pulse), .overwrite_pulse(overwrite_pulse),
        .fault_blk(fault_blk), .done_ok(done_ok), .cmd_reset(cmd_reset),
        .erase_armed(erase_armed), .prot_abort(prot_abort),
        .oe_n(oe_n), .ce_n(ce_n), .status_o(status_o)
    );

    // behavioural reference state
    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    m_poe = 1, m_pce = 1;
    bit    m_t6 = 0, m_t2 = 0, m_err = 0;
    int    m_fblk = 0, m_pend = 0, m_prot = 0;

    function automatic logic [7:0] expect_byte();
        bit inm, hit;
        logic [7:0] e;
        inm = erase_mask[rd_blk];
        hit = m_err && (int'(rd_blk) == m_fblk);
        e = 8'h00;
        case (op_mode)
            3'd1, 3'd4: begin
                e[7] = ~wr_data[7]; e[6] = m_t6; e[5] = m_err; e[2] = 1'b1;
            end
            3'd2: begin
                e[6] = m_t6; e[5] = m_err; e[3] = (m_pend == 0);
                e[2] = inm ? m_t2 : 1'b1;
            end
            3'd3: begin
                if (inm) begin e[7] = 1; e[6] = 1; e[5] = m_err; e[2] = m_t2; end
                else e = array_q;
            end
            3'd0: begin
                if (m_prot > 0) begin e[6] = m_t6; e[5] = m_err; e[2] = 1'b1; end
                else if (m_err) begin e[5] = 1'b1; e[2] = hit ? m_t2 : 1'b1; end
                else e = array_q;
            end
            default: e = array_q;
        endcase
        return e;
    endfunction

    task automatic model_edge();
        bit stb, inm, prot_on, hit, busy_op;
        if (rst) begin
            m_poe = 1; m_pce = 1; m_t6 = 0; m_t2 = 0; m_err = 0;
            m_fblk = 0; m_pend = 0; m_prot = 0;
            return;
        end
        stb     = (oe_n && !m_poe) || (ce_n && !m_pce && !oe_n);
        inm     = erase_mask[rd_blk];
        prot_on = (m_prot > 0);
        hit     = m_err && (int'(rd_blk) == m_fblk);
        busy_op = (op_mode == 3'd1) || (op_mode == 3'd2) || (op_mode == 3'd4);
        if (stb && (busy_op || (op_mode == 3'd0 && prot_on))) m_t6 = !m_t6;
        if (stb && ((((op_mode == 3'd2) || (op_mode == 3'd3)) && inm) ||
                    (op_mode == 3'd0 && !prot_on && hit))) m_t2 = !m_t2;
        if (fault_pulse || overwrite_pulse) begin m_err = 1; m_fblk = int'(fault_blk); end
        else if (cmd_reset || done_ok) m_err = 0;
        m_pend = erase_armed ? TMO : ((m_pend > 0) ? m_pend - 1 : 0);
        m_prot = prot_abort ? PROT : ((m_prot > 0) ? m_prot - 1 : 0);
        m_poe = oe_n; m_pce = ce_n;
    endtask

    task automatic tick();
        logic [7:0] exp_v;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_v = expect_byte();
        vectors++;
        if (status_o !== exp_v) begin
            fails++;
            $display("FAIL %s: status_o=%02h expected %02h (mode %0d blk %0d)",
                     cur_req, status_o, exp_v, op_mode, rd_blk);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic oe_read();
        oe_n = 1'b0; tick(); oe_n = 1'b1; tick();
    endtask

    task automatic ce_read_oe_low();
        oe_n = 1'b0; tick(); ce_n = 1'b0; tick(); ce_n = 1'b1; tick(); oe_n = 1'b1; tick();
    endtask

    task automatic ce_pulse_oe_high();
        ce_n = 1'b0; tick(); ce_n = 1'b1; tick();
    endtask

    task automatic pulse_then(ref logic sig);
        sig = 1'b1; tick(); sig = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; ticks(3); rst = 1'b0;

        // R1: pass-through in idle and for unused mode codes
        cur_req = "R1";
        for (int v = 0; v < 6; v++) begin
            array_q = 8'(v * 37 + 5); rd_blk = BW'(v); tick();
        end
        op_mode = 3'd6; array_q = 8'hC3; tick(); oe_read();
        op_mode = 3'd0;

        // R2/R5: program mode polling and primary toggle
        cur_req = "R2"; op_mode = 3'd1; wr_data = 8'h80; tick();
        wr_data = 8'h7F; tick();
        cur_req = "R5";
        for (int k = 0; k < 3; k++) oe_read();
        ce_pulse_oe_high(); ce_pulse_oe_high();
        ce_read_oe_low(); ce_read_oe_low();

        // R9/R3/R6: erase with timer window and block mask
        cur_req = "R9"; op_mode = 3'd2; erase_mask = 8'b0010_0100;
        erase_armed = 1'b1; tick(); erase_armed = 1'b0;
        ticks(TMO + 2);
        cur_req = "R3"; rd_blk = 3'd2; array_q = 8'hFF; tick();
        cur_req = "R6";
        for (int k = 0; k < 3; k++) begin
            rd_blk = 3'd2; oe_read();
            rd_blk = 3'd3; oe_read();
            rd_blk = 3'd5; oe_read();
        end

        // R4: suspend read, masked and unmasked blocks
        cur_req = "R4"; op_mode = 3'd3;
        rd_blk = 3'd5; tick(); oe_read(); oe_read();
        rd_blk = 3'd1; array_q = 8'h5A; tick(); oe_read();
        rd_blk = 3'd2; ce_read_oe_low();

        // R2: suspend-program mode
        cur_req = "R2"; op_mode = 3'd4; rd_blk = 3'd1; wr_data = 8'h01;
        oe_read(); oe_read();
        erase_mask = '0;

        // R7/R8: fault latch, idle fault display, clearing
        cur_req = "R7"; op_mode = 3'd1; fault_blk = 3'd6; pulse_then(fault_pulse); tick();
        cur_req = "R8"; op_mode = 3'd0; array_q = 8'h11;
        rd_blk = 3'd6; oe_read(); oe_read(); oe_read();
        rd_blk = 3'd0; oe_read(); oe_read();
        cur_req = "R7"; pulse_then(cmd_reset); tick();
        fault_blk = 3'd0; pulse_then(overwrite_pulse); tick();
        rd_blk = 3'd0; oe_read();
        pulse_then(done_ok); tick();
        fault_pulse = 1; cmd_reset = 1; fault_blk = 3'd4; tick();
        fault_pulse = 0; cmd_reset = 0; tick();
        rd_blk = 3'd4; oe_read();
        pulse_then(cmd_reset); tick();

        // R10: protected-abort window in idle
        cur_req = "R10"; array_q = 8'hA5; rd_blk = 3'd3;
        pulse_then(prot_abort);
        oe_read(); oe_read(); ce_pulse_oe_high();
        ticks(PROT);
        cur_req = "R1"; oe_read(); tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule